// File: doc/BRIEF.md
# Game Mode Controller

This block is the top-level mode controller of a hardware arcade game. Four states drive it: READY (title screen), PLAY (normal round), SHIELD (invulnerable round) and OVER (game-over screen). It takes edge-detected key pulses and a collision report from the collision logic. From these it decides whether physics and scrolling may advance, when the score is cleared, which full-screen overlay the renderer shows, and whether a collision ends the round or removes the column that was struck.

The collision report is a valid flag with the index of the column that was hit. Whether that report matters depends on the current state. In PLAY it ends the round. In SHIELD it becomes a destroy request for that column. In READY and OVER it is dropped. The shield key switches a running round between PLAY and SHIELD. The flap key starts a round from the title screen and returns from the game-over screen to the title.

Transitions: READY→PLAY on flap; PLAY→OVER on a valid hit; PLAY→SHIELD and SHIELD→PLAY on the shield key; OVER→READY on flap. Every other input combination leaves the state unchanged.

Top module: `game_mode_ctrl`

## Requirements
- R1: After reset the block is in READY. mode_o is 0, play_en is 0, score_clr is 0, destroy_valid is 0 and screen_sel is 1 (title).
- R2: A flap pulse in READY moves to PLAY (mode_o = 1) on the next clock edge. play_en rises and score_clr is high for exactly that one following cycle. score_clr is never high outside PLAY.
- R3: A valid in-range hit in PLAY moves to OVER (mode_o = 3) on the next edge, and play_en falls to 0.
- R4: In PLAY, when a valid hit and a shield pulse arrive in the same cycle, the hit wins and the block goes to OVER.
- R5: A shield pulse toggles PLAY to SHIELD (mode_o = 2) and SHIELD back to PLAY on the next edge. play_en stays 1 throughout.
- R6: A shield pulse has no effect in READY or OVER.
- R7: A valid in-range hit in SHIELD raises destroy_valid for the next cycle with destroy_col equal to the reported column, and the state stays SHIELD. If a shield pulse comes in the same cycle, the destroy is still issued and the state becomes PLAY.
- R8: Hits in READY or OVER change no state and raise no destroy. A hit in PLAY never raises destroy.
- R9: A flap pulse in OVER moves to READY (mode_o = 0) on the next edge. A flap pulse in PLAY or SHIELD leaves the state unchanged.
- R10: screen_sel is 1 in READY, 2 in OVER and 0 in PLAY and SHIELD. play_en is 1 exactly in PLAY and SHIELD.
- R11: A hit whose column index is NUM_COLS or greater is treated as no hit in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Game clock (50 MHz domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| flap_pulse | input | 1 | One-cycle flap/start key pulse |
| shield_pulse | input | 1 | One-cycle shield toggle key pulse |
| hit_valid | input | 1 | Collision reported this cycle |
| hit_col | input | $clog2(NUM_COLS) | Index of the column that was hit |
| mode_o | output | 2 | Current state: 0 READY, 1 PLAY, 2 SHIELD, 3 OVER |
| play_en | output | 1 | Physics and scrolling may advance |
| score_clr | output | 1 | One-cycle score clear at round start |
| destroy_valid | output | 1 | Request to remove a column |
| destroy_col | output | $clog2(NUM_COLS) | Column to remove, valid with destroy_valid |
| screen_sel | output | 2 | Overlay: 0 none, 1 title, 2 game over |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it are sampled. mode_o, play_en and screen_sel follow the state register. score_clr and the destroy pair come from their own registers that load on that same edge. The driver applies one input vector per falling edge and queues the outputs it expects after the following rising edge. The monitor samples one nanosecond after each rising edge, so each queued item is compared in the single cycle where it must appear. A one-cycle pulse that arrives late or lasts too long therefore shows up as a mismatch.

// File: rtl/gm_pkg.sv
package gm_pkg;

    typedef enum logic [1:0] {
        GM_READY  = 2'd0,
        GM_PLAY   = 2'd1,
        GM_SHIELD = 2'd2,
        GM_OVER   = 2'd3
    } gm_mode_e;

    typedef enum logic [1:0] {
        SCR_NONE  = 2'd0,
        SCR_TITLE = 2'd1,
        SCR_OVER  = 2'd2
    } gm_screen_e;

endpackage

// File: rtl/gm_hit_gate.sv
// Qualifies collision reports by state and column range.
module gm_hit_gate
    import gm_pkg::*;
#(
    parameter int NUM_COLS = 5,
    parameter int COL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gm_mode_e         mode,
    input  logic             hit_valid,
    input  logic [COL_W-1:0] hit_col,
    output logic             hit_fatal,
    output logic             destroy_valid,
    output logic [COL_W-1:0] destroy_col
);

    logic col_ok;
    logic hit_ok;
    logic absorb;

    generate
        if (NUM_COLS == (1 << COL_W)) begin : g_full_range
            assign col_ok = 1'b1;
        end else begin : g_part_range
            assign col_ok = (int'(hit_col) < NUM_COLS);
        end
    endgenerate

    assign hit_ok = hit_valid && col_ok;

    always_comb begin
        hit_fatal = 1'b0;
        absorb    = 1'b0;
        unique case (mode)
            GM_PLAY:   hit_fatal = hit_ok;
            GM_SHIELD: absorb    = hit_ok;
            GM_READY,
            GM_OVER:   ;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            destroy_valid <= 1'b0;
            destroy_col   <= '0;
        end else begin
            destroy_valid <= absorb;
            if (absorb) begin
                destroy_col <= hit_col;
            end
        end
    end

    AST_DESTROY_FROM_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
        destroy_valid |-> ($past(mode) == GM_SHIELD && $past(hit_valid))); // R7
    AST_DESTROY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        destroy_valid |-> (int'(destroy_col) < NUM_COLS)); // R11

endmodule

// File: rtl/gm_mode_fsm.sv
// State register and next-state logic.
module gm_mode_fsm
    import gm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flap_pulse,
    input  logic     shield_pulse,
    input  logic     hit_fatal,
    output gm_mode_e mode
);

    gm_mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            GM_READY: begin
                if (flap_pulse) mode_nx = GM_PLAY;
            end
            GM_PLAY: begin
                if (hit_fatal)         mode_nx = GM_OVER;
                else if (shield_pulse) mode_nx = GM_SHIELD;
            end
            GM_SHIELD: begin
                if (shield_pulse) mode_nx = GM_PLAY;
            end
            GM_OVER: begin
                if (flap_pulse) mode_nx = GM_READY;
            end
            default: mode_nx = GM_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= GM_READY;
        end else begin
            mode <= mode_nx;
        end
    end

    AST_PLAY_TO_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_PLAY && hit_fatal) |=> (mode == GM_OVER)); // R3
    AST_SHIELD_KEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_READY && !flap_pulse) |=> (mode == GM_READY)); // R6
    AST_OVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_OVER && !flap_pulse) |=> (mode == GM_OVER)); // R8

endmodule

// File: rtl/gm_out_decode.sv
// Output process: play enable, overlay select, score clear pulse.
module gm_out_decode
    import gm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gm_mode_e   mode,
    input  logic       flap_pulse,
    output logic       play_en,
    output gm_screen_e screen_sel,
    output logic       score_clr
);

    always_comb begin
        play_en    = 1'b0;
        screen_sel = SCR_NONE;
        unique case (mode)
            GM_READY:  screen_sel = SCR_TITLE;
            GM_PLAY:   play_en    = 1'b1;
            GM_SHIELD: play_en    = 1'b1;
            GM_OVER:   screen_sel = SCR_OVER;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_clr <= 1'b0;
        end else begin
            score_clr <= (mode == GM_READY) && flap_pulse;
        end
    end

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        score_clr |=> !score_clr); // R2
    AST_CLR_IN_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        score_clr |-> (mode == GM_PLAY)); // R2
    AST_OVERLAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        play_en |-> (screen_sel == SCR_NONE)); // R10

endmodule

// File: rtl/game_mode_ctrl.sv
module game_mode_ctrl
    import gm_pkg::*;
#(
    parameter  int NUM_COLS = 5,
    localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flap_pulse,
    input  logic             shield_pulse,
    input  logic             hit_valid,
    input  logic [COL_W-1:0] hit_col,
    output logic [1:0]       mode_o,
    output logic             play_en,
    output logic             score_clr,
    output logic             destroy_valid,
    output logic [COL_W-1:0] destroy_col,
    output logic [1:0]       screen_sel
);

    gm_mode_e   mode;
    gm_screen_e scr;
    logic       hit_fatal;

    gm_hit_gate #(
        .NUM_COLS (NUM_COLS),
        .COL_W    (COL_W)
    ) u_hit_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .hit_valid     (hit_valid),
        .hit_col       (hit_col),
        .hit_fatal     (hit_fatal),
        .destroy_valid (destroy_valid),
        .destroy_col   (destroy_col)
    );

    gm_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flap_pulse   (flap_pulse),
        .shield_pulse (shield_pulse),
        .hit_fatal    (hit_fatal),
        .mode         (mode)
    );

    gm_out_decode u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .flap_pulse (flap_pulse),
        .play_en    (play_en),
        .screen_sel (scr),
        .score_clr  (score_clr)
    );

    assign mode_o     = mode;
    assign screen_sel = scr;

    AST_HIT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_PLAY && hit_valid && shield_pulse && int'(hit_col) < NUM_COLS)
        |=> (mode == GM_OVER)); // R4
    AST_SHIELD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GM_SHIELD && shield_pulse) |=> (mode == GM_PLAY)); // R5

endmodule

// File: tb/test_game_mode_ctrl.sv
module test_game_mode_ctrl;

    localparam int NC = 5;

    typedef struct packed {
        logic [1:0] mode;
        logic       play;
        logic       clr;
        logic       dv;
        logic [2:0] dc;
        logic [1:0] scr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flap_pulse = 1'b0;
    logic       shield_pulse = 1'b0;
    logic       hit_valid = 1'b0;
    logic [2:0] hit_col = '0;
    logic [1:0] mode_o;
    logic       play_en;
    logic       score_clr;
    logic       destroy_valid;
    logic [2:0] destroy_col;
    logic [1:0] screen_sel;

    int n_run  = 0;
    int n_fail = 0;
    logic [1:0] m = 2'd0;
    exp_t  exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    always #5 clk = ~clk;

    game_mode_ctrl #(.NUM_COLS(NC)) i_game_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .flap_pulse    (flap_pulse),
        .shield_pulse  (shield_pulse),
        .hit_valid     (hit_valid),
        .hit_col       (hit_col),
        .mode_o        (mode_o),
        .play_en       (play_en),
        .score_clr     (score_clr),
        .destroy_valid (destroy_valid),
        .destroy_col   (destroy_col),
        .screen_sel    (screen_sel)
    );

    function automatic exp_t outs_for(input logic [1:0] md);
        exp_t e;
        e = '0;
        e.mode = md;
        e.play = (md == 2'd1 || md == 2'd2);
        e.scr  = (md == 2'd0) ? 2'd1 : (md == 2'd3) ? 2'd2 : 2'd0;
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        bit bad;
        bad = (mode_o !== e.mode) || (play_en !== e.play) || (score_clr !== e.clr)
           || (screen_sel !== e.scr) || (destroy_valid !== e.dv)
           || (e.dv && destroy_col !== e.dc);
        n_run++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: got mode=%0d play=%0d clr=%0d dv=%0d dc=%0d scr=%0d, expected mode=%0d play=%0d clr=%0d dv=%0d dc=%0d scr=%0d",
                     tag, mode_o, play_en, score_clr, destroy_valid, destroy_col, screen_sel,
                     e.mode, e.play, e.clr, e.dv, e.dc, e.scr);
        end
    endtask

    // Driver: apply inputs on the falling edge, queue the outputs due after the next rising edge.
    task automatic drive(input logic f, input logic s, input logic h,
                         input logic [2:0] c, input string tag);
        logic hit_ok;
        logic [1:0] nx;
        exp_t e;
        @(negedge clk);
        flap_pulse   = f;
        shield_pulse = s;
        hit_valid    = h;
        hit_col      = c;
        hit_ok = h && (int'(c) < NC);
        nx = m;
        case (m)
            2'd0: if (f) nx = 2'd1;
            2'd1: if (hit_ok) nx = 2'd3; else if (s) nx = 2'd2;
            2'd2: if (s) nx = 2'd1;
            default: if (f) nx = 2'd0;
        endcase
        e = outs_for(nx);
        e.clr = (m == 2'd0) && f;
        e.dv  = (m == 2'd2) && hit_ok;
        e.dc  = c;
        m = nx;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: one nanosecond after each rising edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                compare(exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got no finish, expected end of sequence");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(outs_for(2'd0), "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare(outs_for(2'd0), "R1 after release");

        drive(0, 0, 1, 3'd1, "R8 hit in READY ignored");
        drive(0, 1, 0, 3'd0, "R6 shield in READY ignored");
        drive(1, 0, 0, 3'd0, "R2 flap starts round");
        drive(0, 0, 0, 3'd0, "R2 score clear drops");
        drive(1, 0, 0, 3'd0, "R9 flap in PLAY no change");
        drive(0, 0, 1, 3'd7, "R11 out-of-range hit in PLAY");
        drive(0, 1, 0, 3'd0, "R5 shield enters SHIELD");
        drive(1, 0, 0, 3'd0, "R9 flap in SHIELD no change");
        drive(0, 0, 1, 3'd3, "R7 hit destroys col 3");
        drive(0, 0, 1, 3'd4, "R7 hit destroys top col 4");
        drive(0, 0, 1, 3'd5, "R11 col 5 ignored in SHIELD");
        drive(0, 0, 0, 3'd0, "R7 destroy clears");
        drive(0, 1, 1, 3'd0, "R7 destroy with toggle back");
        drive(0, 0, 0, 3'd0, "R5 back in PLAY");
        drive(0, 1, 1, 3'd2, "R4 hit beats shield key");
        drive(0, 1, 0, 3'd0, "R6 shield in OVER ignored");
        drive(0, 0, 1, 3'd2, "R8 hit in OVER ignored");
        drive(1, 0, 0, 3'd0, "R9 flap returns to READY");
        drive(0, 0, 0, 3'd0, "R10 title screen");
        drive(1, 1, 0, 3'd0, "R2 start with shield key");
        drive(0, 1, 0, 3'd0, "R5 toggle to SHIELD");
        drive(0, 1, 0, 3'd0, "R5 toggle to PLAY");
        drive(0, 0, 1, 3'd0, "R3 hit ends round");
        drive(0, 0, 0, 3'd0, "R10 game-over screen");
        drive(0, 0, 0, 3'd0, "R3 stays OVER");

        @(negedge clk);
        flap_pulse = 0; shield_pulse = 0; hit_valid = 0;
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule